// File: doc/BRIEF.md
# Next-PC and Address Generator

This combinational block works out two things for a small 16-bit machine: the next value of the program counter and the address that goes into the memory address register. At its centre is one address adder. One input of the adder is either the current PC or a base register value. The other input is an offset taken from the instruction word and sign-extended from 6, 9 or 11 bits, or a zero offset. The block does not hold the PC, the register file or memory. It expects the PC input to carry the value that fetch has already incremented. It tells the register file which base register to read.

The next PC is picked from four sources: PC+1 for fetch, the adder result for jumps, the shared bus for traps, and a branch-resolved choice. The branch-resolved choice takes the adder result only when the condition mask in the instruction matches a current flag. The address for the memory address register is either the adder result or an 8-bit trap vector from the instruction, zero-extended.

Top module: `nextpc_addr_gen`

## Requirements
- R1: With `off_sel`=01 and `base_sel`=1, `addr_sum` is `base_val` plus `ir[5:0]` sign-extended to 16 bits.
- R2: With `off_sel`=10 and `base_sel`=0, `addr_sum` is `pc` plus `ir[8:0]` sign-extended, so targets run from pc-256 to pc+255.
- R3: With `off_sel`=11, the offset is `ir[10:0]` sign-extended, a range of -1024 to +1023.
- R4: With `off_sel`=00 the offset is zero. A jump (`base_sel`=1, `pc_sel`=01) loads `next_pc` with the full `base_val`.
- R5: All address arithmetic wraps modulo 2^16.
- R6: With `pc_sel`=00, `next_pc` is `pc`+1, and 16'hFFFF is followed by 16'h0000.
- R7: With `pc_sel`=10, `next_pc` equals `bus`.
- R8: `flags` is {n,z,p}, and `ir[11]`, `ir[10]` and `ir[9]` request n, z and p. `br_taken` is 1 when any requested flag is set.
- R9: A mask `ir[11:9]`=000 is never taken. A mask of 111 is taken whichever single flag is set.
- R10: With `mar_sel`=1, `mar_addr` is {8'h00, `ir[7:0]`}. With `mar_sel`=0 it equals `addr_sum`.
- R11: `base_idx` equals `ir[8:6]`.
- R12: With `pc_sel`=11, `next_pc` is `addr_sum` when `br_taken` is 1 and `pc` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ir | input | 16 | Current instruction word |
| pc | input | 16 | Program counter, already incremented |
| base_val | input | 16 | Value read from the base register |
| bus | input | 16 | Shared data bus value |
| flags | input | 3 | Condition flags {n,z,p} |
| base_sel | input | 1 | Adder base: 0 = PC, 1 = base register |
| off_sel | input | 2 | Offset: 00 zero, 01 6-bit, 10 9-bit, 11 11-bit |
| pc_sel | input | 2 | Next PC: 00 PC+1, 01 adder, 10 bus, 11 branch-resolved |
| mar_sel | input | 1 | MAR source: 0 adder, 1 zero-extended vector |
| base_idx | output | 3 | Index of the base register to read |
| addr_sum | output | 16 | Address adder result |
| next_pc | output | 16 | Selected next program counter |
| mar_addr | output | 16 | Selected memory address |
| br_taken | output | 1 | Branch condition result |

## Verification
Each offset width is tried at its most positive and most negative field values. These cases show true sign extension apart from zero extension, and they show that the right slice of the instruction is used for each width. The adder is also driven across 16'hFFFF and below 16'h0000, which checks that it wraps rather than saturates. Branch masks are tried against each single flag: a single matching bit, a single non-matching bit, a mixed mask, and the all-zero and all-one masks. This tells an "any match" rule apart from an "all match" rule. The trap vector is given with the upper instruction bits set, so that zero extension can be seen in the upper byte.

// File: rtl/nextpc_addr_gen.sv
module nextpc_addr_gen #(
  parameter int DW = 16,
  parameter int RIW = 3
) (
  input  logic [DW-1:0]  ir,
  input  logic [DW-1:0]  pc,
  input  logic [DW-1:0]  base_val,
  input  logic [DW-1:0]  bus,
  input  logic [2:0]     flags,
  input  logic           base_sel,
  input  logic [1:0]     off_sel,
  input  logic [1:0]     pc_sel,
  input  logic           mar_sel,
  output logic [RIW-1:0] base_idx,
  output logic [DW-1:0]  addr_sum,
  output logic [DW-1:0]  next_pc,
  output logic [DW-1:0]  mar_addr,
  output logic           br_taken
);
  localparam int VW = 8;

  logic [DW-1:0] off_val;
  logic [DW-1:0] adder_base;

  assign base_idx   = ir[8:6];
  assign adder_base = base_sel ? base_val : pc;

  always_comb begin
    case (off_sel)
      2'b01:   off_val = {{(DW-6){ir[5]}}, ir[5:0]};
      2'b10:   off_val = {{(DW-9){ir[8]}}, ir[8:0]};
      2'b11:   off_val = {{(DW-11){ir[10]}}, ir[10:0]};
      default: off_val = '0;
    endcase
  end

  assign addr_sum = adder_base + off_val;
  assign br_taken = |(ir[11:9] & flags);

  always_comb begin
    case (pc_sel)
      2'b00:   next_pc = pc + DW'(1);
      2'b01:   next_pc = addr_sum;
      2'b10:   next_pc = bus;
      default: next_pc = br_taken ? addr_sum : pc;
    endcase
  end

  assign mar_addr = mar_sel ? {{(DW-VW){1'b0}}, ir[VW-1:0]} : addr_sum;

  always_comb begin
    p_mask_none_r9: assert (ir[11:9] != 3'b000 || !br_taken);
    p_br_hold_r12: assert (pc_sel != 2'b11 || br_taken || next_pc == pc);
    p_vec_upper_r10: assert (!mar_sel || mar_addr[DW-1:VW] == '0);
    p_zero_off_r4: assert (off_sel != 2'b00 || !base_sel || addr_sum == base_val);
    p_mar_adder_r10: assert (mar_sel || mar_addr == addr_sum);
  end
endmodule

// File: tb/test_nextpc_addr_gen.sv
module test_nextpc_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] ir, pc, base_val, bus;
  logic [2:0] flags;
  logic base_sel, mar_sel;
  logic [1:0] off_sel, pc_sel;
  logic [2:0] base_idx;
  logic [15:0] addr_sum, next_pc, mar_addr;
  logic br_taken;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nextpc_addr_gen i_nextpc_addr_gen (
    .ir(ir), .pc(pc), .base_val(base_val), .bus(bus), .flags(flags),
    .base_sel(base_sel), .off_sel(off_sel), .pc_sel(pc_sel), .mar_sel(mar_sel),
    .base_idx(base_idx), .addr_sum(addr_sum), .next_pc(next_pc),
    .mar_addr(mar_addr), .br_taken(br_taken)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] i, logic [15:0] p, logic [15:0] b, logic bs, logic [1:0] os,
                       logic [1:0] ps, logic ms, logic [2:0] f);
    @(negedge clk);
    ir = i; pc = p; base_val = b; base_sel = bs; off_sel = os; pc_sel = ps; mar_sel = ms; flags = f;
    #1;
  endtask

  task automatic t_idle();
    apply(16'h0000, 16'h0000, 16'h0000, 0, 2'b00, 2'b00, 0, 3'b000);
    chk("R6 idle next_pc", next_pc, 16'h0001);
    chk("R9 idle br_taken", {15'b0, br_taken}, 16'h0000);
  endtask

  task automatic t_base_idx_r11();
    apply(16'b0000_000_101_000000, 16'h0, 16'h0, 0, 2'b00, 2'b00, 0, 3'b000);
    chk("R11 base_idx=5", {13'b0, base_idx}, 16'h0005);
    apply(16'b0000_000_010_111111, 16'h0, 16'h0, 0, 2'b00, 2'b00, 0, 3'b000);
    chk("R11 base_idx=2", {13'b0, base_idx}, 16'h0002);
  endtask

  task automatic t_off6_r1();
    apply(16'h003F, 16'h5555, 16'h1000, 1, 2'b01, 2'b00, 0, 3'b000);
    chk("R1 off6 -1", addr_sum, 16'h0FFF);
    apply(16'h001F, 16'h5555, 16'h1000, 1, 2'b01, 2'b00, 0, 3'b000);
    chk("R1 off6 +31", addr_sum, 16'h101F);
    apply(16'h0020, 16'h5555, 16'h1000, 1, 2'b01, 2'b00, 0, 3'b000);
    chk("R1 off6 -32", addr_sum, 16'h0FE0);
  endtask

  task automatic t_off9_r2();
    apply(16'h00FF, 16'h3000, 16'h7777, 0, 2'b10, 2'b00, 0, 3'b000);
    chk("R2 off9 +255", addr_sum, 16'h30FF);
    apply(16'h0100, 16'h3000, 16'h7777, 0, 2'b10, 2'b00, 0, 3'b000);
    chk("R2 off9 -256", addr_sum, 16'h2F00);
  endtask

  task automatic t_off11_r3();
    apply(16'h0400, 16'h3000, 16'h0, 0, 2'b11, 2'b00, 0, 3'b000);
    chk("R3 off11 -1024", addr_sum, 16'h2C00);
    apply(16'h03FF, 16'h3000, 16'h0, 0, 2'b11, 2'b00, 0, 3'b000);
    chk("R3 off11 +1023", addr_sum, 16'h33FF);
  endtask

  task automatic t_jump_r4();
    apply(16'hC1C0, 16'h3000, 16'hABCD, 1, 2'b00, 2'b01, 0, 3'b000);
    chk("R4 jump next_pc", next_pc, 16'hABCD);
  endtask

  task automatic t_wrap_r5();
    apply(16'h0001, 16'hFFFF, 16'h0, 0, 2'b10, 2'b00, 0, 3'b000);
    chk("R5 wrap up", addr_sum, 16'h0000);
    apply(16'h01FF, 16'h0000, 16'h0, 0, 2'b10, 2'b00, 0, 3'b000);
    chk("R5 wrap down", addr_sum, 16'hFFFF);
  endtask

  task automatic t_incr_r6();
    apply(16'h0, 16'h1234, 16'h0, 0, 2'b00, 2'b00, 0, 3'b000);
    chk("R6 pc+1", next_pc, 16'h1235);
    apply(16'h0, 16'hFFFF, 16'h0, 0, 2'b00, 2'b00, 0, 3'b000);
    chk("R6 pc+1 wrap", next_pc, 16'h0000);
  endtask

  task automatic t_bus_r7();
    bus = 16'h00AB;
    apply(16'h0025, 16'h3000, 16'h0, 0, 2'b00, 2'b10, 0, 3'b000);
    chk("R7 bus", next_pc, 16'h00AB);
  endtask

  task automatic t_branch_r8();
    apply(16'h0800, 16'h3000, 16'h0, 0, 2'b10, 2'b11, 0, 3'b100);
    chk("R8 n vs n", {15'b0, br_taken}, 16'h0001);
    apply(16'h0400, 16'h3000, 16'h0, 0, 2'b10, 2'b11, 0, 3'b100);
    chk("R8 z vs n", {15'b0, br_taken}, 16'h0000);
    apply(16'h0600, 16'h3000, 16'h0, 0, 2'b10, 2'b11, 0, 3'b001);
    chk("R8 zp vs p", {15'b0, br_taken}, 16'h0001);
  endtask

  task automatic t_mask_r9();
    for (int k = 0; k < 3; k++) begin
      apply(16'h0000, 16'h3000, 16'h0, 0, 2'b10, 2'b11, 0, 3'b001 << k);
      chk("R9 mask 000", {15'b0, br_taken}, 16'h0000);
      apply(16'h0E00, 16'h3000, 16'h0, 0, 2'b10, 2'b11, 0, 3'b001 << k);
      chk("R9 mask 111", {15'b0, br_taken}, 16'h0001);
    end
  endtask

  task automatic t_mar_r10();
    apply(16'hF0FF, 16'h3000, 16'h0, 0, 2'b10, 2'b00, 1, 3'b000);
    chk("R10 vector", mar_addr, 16'h00FF);
    apply(16'h0005, 16'h3000, 16'h0, 0, 2'b10, 2'b00, 0, 3'b000);
    chk("R10 adder", mar_addr, 16'h3005);
  endtask

  task automatic t_resolve_r12();
    apply(16'h0805, 16'h3000, 16'h0, 0, 2'b10, 2'b11, 0, 3'b010);
    chk("R12 not taken", next_pc, 16'h3000);
    apply(16'h0405, 16'h3000, 16'h0, 0, 2'b10, 2'b11, 0, 3'b010);
    chk("R12 taken", next_pc, 16'h3005);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bus = 16'h0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_base_idx_r11();
    t_off6_r1();
    t_off9_r2();
    t_off11_r3();
    t_jump_r4();
    t_wrap_r5();
    t_incr_r6();
    t_bus_r7();
    t_branch_r8();
    t_mask_r9();
    t_mar_r10();
    t_resolve_r12();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule